// File: doc/BRIEF.md
# Integer Twin Butterfly Rounding Unit

This block performs one integer butterfly step of a DCT or FFT kernel in a single operation. It takes two signed data operands and one signed coefficient. From the same operand values it forms both the sum and the difference of the data operands and multiplies each by the coefficient. It then rounds each product half-up and arithmetically shifts it right by an amount taken from the instruction word. Both results appear together, one clock after the request.

The unit also decodes the instruction word it is given. It takes the shift amount and the primary destination register number from that word. The second result is steered to the register numbered one above the primary destination. A set record bit is a reserved encoding: the unit raises an illegal-instruction pulse and leaves all result outputs untouched. Register-file reads are done outside the block, so the operand values arrive on their own ports.

Top module: `twin_bfly_unit`

## Requirements
- R1: `res_sum` equals round_shift(P, n), where P is the low XLEN bits of the signed product (opa + opb) * coef. round_shift(P, n) adds the rounding constant to P modulo 2^XLEN and then shifts arithmetically right by n.
- R2: `res_diff` equals round_shift(Q, n), where Q is the low XLEN bits of (opa - opb) * coef. It uses the same coef and the same operand values as R1.
- R3: For n > 0 the rounding constant is 2^(n-1), so a remainder of exactly one half rounds toward plus infinity. For example, 3 >> 1 gives 2 and -3 >> 1 gives -1.
- R4: When n = 0 no rounding constant is added and the low XLEN bits of each product pass through unchanged.
- R5: The shift is arithmetic. The n vacated upper bits of a result are copies of the sign bit of the rounded product, so negative results stay negative.
- R6: The shift amount n is the low log2(XLEN) bits of instruction bits [10:6]. These are bits 21 to 25 when the most significant bit is numbered 0. Any higher bits of that field are ignored.
- R7: On a committed result, `dst_sum` equals instruction bits [25:21] and `dst_diff` equals that value plus one, modulo 32 (31 becomes 0).
- R8: A request with instruction bit [0] = 1 (the record bit) is reserved. It pulses `illegal` one cycle later, keeps `out_valid` low, and leaves `res_sum`, `res_diff`, `dst_sum` and `dst_diff` at their previous values.
- R9: A request with bit [0] = 0 raises `out_valid` for exactly the next cycle, with both results present. Back-to-back requests each produce one result. With no request, `out_valid` and `illegal` are low.
- R10: During and right after reset, `out_valid`, `illegal`, both results and both destination numbers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| insn | input | 32 | Instruction word (destination, shift field, record bit) |
| opa | input | XLEN | First signed data operand |
| opb | input | XLEN | Second signed data operand |
| coef | input | XLEN | Signed coefficient shared by both products |
| out_valid | output | 1 | Results valid strobe |
| illegal | output | 1 | Reserved-encoding pulse |
| res_sum | output | XLEN | Rounded, shifted (opa+opb)*coef |
| res_diff | output | XLEN | Rounded, shifted (opa-opb)*coef |
| dst_sum | output | 5 | Register number for res_sum |
| dst_diff | output | 5 | Register number for res_diff |

## Verification
The bench builds the unit with XLEN = 16 and the rotate-and-mask shifter. At this width a 64-bit signed reference computes every full product exactly before it is reduced to the low half, so wrap-around of the low half is checked and not avoided. A 4-bit shift field makes every shift from 0 to 15 reachable, and the ignored top bit of the field can be set on purpose. Extreme operands (-32768, 32767) are covered, and the half-way rounding cases are reached by direct choice of small operands.

// File: rtl/twin_bfly_pkg.sv
package twin_bfly_pkg;
   // Instruction field positions, little-endian bit indices of a 32-bit word
   localparam int RT_LSB = 21;
   localparam int SH_LSB = 6;
   localparam int RC_BIT = 0;
   localparam int FLD_W  = 5;

   typedef struct packed {
      logic [FLD_W-1:0] rt;
      logic [FLD_W-1:0] sh;
      logic             rc;
   } bfly_fields_t;
endpackage

// File: rtl/twin_bfly_decode.sv
module twin_bfly_decode
   import twin_bfly_pkg::*;
(
   input  logic [31:0]      insn,
   output bfly_fields_t     fields,
   output logic [FLD_W-1:0] rt_next
);
   always_comb begin
      fields.rt = insn[RT_LSB +: FLD_W];
      fields.sh = insn[SH_LSB +: FLD_W];
      fields.rc = insn[RC_BIT];
      rt_next   = fields.rt + FLD_W'(1);
   end
endmodule

// File: rtl/twin_bfly_combine.sv
module twin_bfly_combine #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   input  logic [XLEN-1:0] coef,
   output logic [XLEN-1:0] prod_sum_lo,
   output logic [XLEN-1:0] prod_diff_lo
);
   localparam int PW = 2 * XLEN;

   logic signed [XLEN-1:0] sum_v, diff_v;
   logic signed [PW-1:0]   prod_s, prod_d;

   always_comb begin
      sum_v        = $signed(opa) + $signed(opb);
      diff_v       = $signed(opa) - $signed(opb);
      prod_s       = PW'(sum_v) * PW'($signed(coef));
      prod_d       = PW'(diff_v) * PW'($signed(coef));
      prod_sum_lo  = prod_s[XLEN-1:0];
      prod_diff_lo = prod_d[XLEN-1:0];
   end
endmodule

// File: rtl/twin_bfly_round_shift.sv
module twin_bfly_round_shift #(
   parameter int XLEN       = 32,
   parameter int SHIFT_IMPL = 0,
   localparam int NW        = $clog2(XLEN)
) (
   input  logic [XLEN-1:0] prod_lo,
   input  logic [NW-1:0]   n,
   output logic [XLEN-1:0] res
);
   logic [XLEN-1:0] rnd_k, rounded;

   always_comb begin
      rnd_k   = (n == '0) ? '0 : (XLEN'(1) << (n - NW'(1)));
      rounded = prod_lo + rnd_k;
   end

   generate
      if (SHIFT_IMPL == 0) begin : g_rotmask
         logic [2*XLEN-1:0] dbl;
         logic [XLEN-1:0]   keep_m;
         always_comb begin
            dbl    = {rounded, rounded} >> n;
            keep_m = {XLEN{1'b1}} >> n;
            res    = (dbl[XLEN-1:0] & keep_m) | ({XLEN{rounded[XLEN-1]}} & ~keep_m);
         end
      end else begin : g_arith
         always_comb res = XLEN'($signed(rounded) >>> n);
      end
   endgenerate

   always_comb begin
      // R4
      if (n == '0) zero_shift_chk: assert (res == prod_lo);
      // R5
      if (n != '0) sign_fill_chk: assert (res[XLEN-1] == rounded[XLEN-1]);
   end
endmodule

// File: rtl/twin_bfly_unit.sv
module twin_bfly_unit
   import twin_bfly_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int SHIFT_IMPL = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [31:0]     insn,
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   input  logic [XLEN-1:0] coef,
   output logic            out_valid,
   output logic            illegal,
   output logic [XLEN-1:0] res_sum,
   output logic [XLEN-1:0] res_diff,
   output logic [4:0]      dst_sum,
   output logic [4:0]      dst_diff
);
   localparam int NW = $clog2(XLEN);

   generate
      if (XLEN < 8 || XLEN > 32 || (1 << NW) != XLEN) begin : g_bad_xlen
         $error("twin_bfly_unit: XLEN must be a power of two from 8 to 32");
      end
      if (SHIFT_IMPL != 0 && SHIFT_IMPL != 1) begin : g_bad_impl
         $error("twin_bfly_unit: SHIFT_IMPL must be 0 or 1");
      end
   endgenerate

   bfly_fields_t     fld;
   logic [FLD_W-1:0] rt_up;
   logic [XLEN-1:0]  p_sum, p_diff, r_sum, r_diff;
   logic [NW-1:0]    shamt;
   logic             commit;

   twin_bfly_decode u_dec (.insn(insn), .fields(fld), .rt_next(rt_up));

   twin_bfly_combine #(.XLEN(XLEN)) u_comb (
      .opa(opa), .opb(opb), .coef(coef),
      .prod_sum_lo(p_sum), .prod_diff_lo(p_diff)
   );

   always_comb begin
      shamt  = fld.sh[NW-1:0];
      commit = in_valid & ~fld.rc;
   end

   twin_bfly_round_shift #(.XLEN(XLEN), .SHIFT_IMPL(SHIFT_IMPL)) u_rs_sum (
      .prod_lo(p_sum), .n(shamt), .res(r_sum)
   );
   twin_bfly_round_shift #(.XLEN(XLEN), .SHIFT_IMPL(SHIFT_IMPL)) u_rs_diff (
      .prod_lo(p_diff), .n(shamt), .res(r_diff)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         illegal   <= 1'b0;
         res_sum   <= '0;
         res_diff  <= '0;
         dst_sum   <= '0;
         dst_diff  <= '0;
      end else begin
         out_valid <= commit;
         illegal   <= in_valid & fld.rc;
         if (commit) begin
            res_sum  <= r_sum;
            res_diff <= r_diff;
            dst_sum  <= fld.rt;
            dst_diff <= rt_up;
         end
      end
   end

   // R9
   valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !insn[0] |=> out_valid && !illegal);
   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && !illegal);
   // R8
   rc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && insn[0] |=> illegal && !out_valid && $stable(res_sum) && $stable(res_diff));
   // R7
   dst_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> dst_diff == dst_sum + 5'd1);
endmodule

// File: tb/twin_bfly_unit_tb.sv
`timescale 1ns/1ps
module twin_bfly_unit_tb;
   localparam int XW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [31:0]   insn = '0;
   logic [XW-1:0] opa = '0, opb = '0, coef = '0;
   logic          out_valid, illegal;
   logic [XW-1:0] res_sum, res_diff;
   logic [4:0]    dst_sum, dst_diff;

   always #2.5 clk = ~clk;

   twin_bfly_unit #(.XLEN(XW), .SHIFT_IMPL(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
      .opa(opa), .opb(opb), .coef(coef),
      .out_valid(out_valid), .illegal(illegal),
      .res_sum(res_sum), .res_diff(res_diff),
      .dst_sum(dst_sum), .dst_diff(dst_diff)
   );

   typedef struct {
      int            kind;   // 0 idle, 1 commit, 2 reserved
      logic [XW-1:0] e_sum;
      logic [XW-1:0] e_diff;
      logic [4:0]    e_dsum;
      logic [4:0]    e_ddiff;
      string         tag;
   } exp_t;

   exp_t          exp_q[$];
   int            n_tests = 0;
   int            n_fail  = 0;
   logic [XW-1:0] hold_sum = '0, hold_diff = '0;
   logic [4:0]    hold_dsum = '0, hold_ddiff = '0;

   task automatic check(input bit ok, input string req, input longint act, input longint expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   function automatic logic [XW-1:0] ref_rs(input longint p, input int n);
      logic [XW-1:0] lo;
      lo = p[XW-1:0];
      if (n > 0) lo = lo + XW'(1 << (n - 1));
      return XW'($signed(lo) >>> n);
   endfunction

   function automatic logic [31:0] mk_insn(input logic [4:0] rt, input logic [4:0] sh, input logic rc);
      return {6'd4, rt, 5'd3, 5'd5, sh, 5'd11, rc};
   endfunction

   task automatic op(input logic signed [XW-1:0] a, input logic signed [XW-1:0] b,
                     input logic signed [XW-1:0] c, input logic [4:0] rt,
                     input logic [4:0] sh, input logic rc, input string tag);
      exp_t   e;
      longint ps, pd;
      int     n;
      @(negedge clk);
      in_valid = 1'b1;
      insn     = mk_insn(rt, sh, rc);
      opa = a; opb = b; coef = c;
      n  = int'(sh) % XW;
      ps = (longint'(a) + longint'(b)) * longint'(c);
      pd = (longint'(a) - longint'(b)) * longint'(c);
      e.kind    = rc ? 2 : 1;
      e.e_sum   = ref_rs(ps, n);
      e.e_diff  = ref_rs(pd, n);
      e.e_dsum  = rt;
      e.e_ddiff = rt + 5'd1;
      e.tag     = tag;
      exp_q.push_back(e);
   endtask

   task automatic idle(input int cycles);
      for (int i = 0; i < cycles; i++) begin
         exp_t e;
         @(negedge clk);
         in_valid = 1'b0;
         opa = $urandom; opb = $urandom; coef = $urandom; insn = $urandom;
         e.kind = 0; e.e_sum = '0; e.e_diff = '0; e.e_dsum = '0; e.e_ddiff = '0;
         e.tag = "R9 idle";
         exp_q.push_back(e);
      end
   endtask

   // Monitor: compares one expected item per cycle, shortly after the edge
   always @(posedge clk) begin
      exp_t e;
      #1;
      if (exp_q.size() > 0) begin
         e = exp_q.pop_front();
         if (e.kind == 1) begin
            check(out_valid === 1'b1, {e.tag, " R9 out_valid"}, longint'(out_valid), 1);
            check(illegal === 1'b0, {e.tag, " R9 illegal"}, longint'(illegal), 0);
            check(res_sum === e.e_sum, {e.tag, " R1 res_sum"}, longint'(res_sum), longint'(e.e_sum));
            check(res_diff === e.e_diff, {e.tag, " R2 res_diff"}, longint'(res_diff), longint'(e.e_diff));
            check(dst_sum === e.e_dsum, {e.tag, " R7 dst_sum"}, longint'(dst_sum), longint'(e.e_dsum));
            check(dst_diff === e.e_ddiff, {e.tag, " R7 dst_diff"}, longint'(dst_diff), longint'(e.e_ddiff));
            hold_sum = e.e_sum; hold_diff = e.e_diff;
            hold_dsum = e.e_dsum; hold_ddiff = e.e_ddiff;
         end else begin
            check(out_valid === 1'b0, {e.tag, " R8/R9 out_valid low"}, longint'(out_valid), 0);
            check(illegal === (e.kind == 2), {e.tag, " R8 illegal"}, longint'(illegal), longint'(e.kind == 2));
            check(res_sum === hold_sum, {e.tag, " R8 res_sum hold"}, longint'(res_sum), longint'(hold_sum));
            check(res_diff === hold_diff, {e.tag, " R8 res_diff hold"}, longint'(res_diff), longint'(hold_diff));
            check(dst_sum === hold_dsum && dst_diff === hold_ddiff, {e.tag, " R8 dst hold"},
                  longint'({dst_sum, dst_diff}), longint'({hold_dsum, hold_ddiff}));
         end
      end
   end

   initial begin
      #900000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R10 reset state
      check(out_valid === 1'b0 && illegal === 1'b0, "R10 strobes", longint'({out_valid, illegal}), 0);
      check(res_sum === '0 && res_diff === '0, "R10 results", longint'({res_sum, res_diff}), 0);
      check(dst_sum === '0 && dst_diff === '0, "R10 dst", longint'({dst_sum, dst_diff}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check(out_valid === 1'b0 && res_sum === '0, "R10 after release", longint'({out_valid, res_sum}), 0);

      idle(2);
      op(16'sd100, 16'sd20, 16'sd3, 5'd4, 5'd0, 1'b0, "R4 n=0");
      op(16'sd3, 16'sd0, 16'sd1, 5'd1, 5'd1, 1'b0, "R3 half up +");
      op(-16'sd3, 16'sd0, 16'sd1, 5'd2, 5'd1, 1'b0, "R3 half up -");
      op(16'sd5, -16'sd9, -16'sd7, 5'd6, 5'd2, 1'b0, "R5 negative");
      op(16'sd1000, -16'sd200, 16'sd11585, 5'd8, 5'd14, 1'b0, "R1 R2 dct");
      op(16'sd77, 16'sd12, 16'sd9, 5'd9, 5'b10011, 1'b0, "R6 high sh bit");
      op(-16'sd32768, 16'sd32767, 16'sd32767, 5'd10, 5'd15, 1'b0, "R5 extremes n=15");
      op(16'sd32767, 16'sd32767, -16'sd32768, 5'd31, 5'd7, 1'b0, "R7 rt wrap");
      op(16'sd44, 16'sd2, 16'sd5, 5'd12, 5'd3, 1'b1, "R8 reserved");
      op(-16'sd1, -16'sd1, 16'sd1, 5'd13, 5'd1, 1'b0, "R3 R5 -1");
      idle(1);
      op(16'sd200, 16'sd100, 16'sd7, 5'd14, 5'd4, 1'b1, "R8 reserved after idle");
      idle(2);

      for (int k = 0; k < 400; k++) begin
         logic [4:0] sh_r;
         sh_r = 5'($urandom);
         op(XW'($urandom), XW'($urandom), XW'($urandom), 5'($urandom), sh_r,
            ($urandom % 8) == 0, "R1 R2 random");
         if (($urandom % 5) == 0) idle(1);
      end
      idle(3);
      wait (exp_q.size() == 0);
      @(posedge clk); #2;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule